// File: doc/BRIEF.md
# Iterative AES Equivalent Inverse Cipher Core

This core turns one 128-bit AES ciphertext block into its 128-bit plaintext, for 128-, 192- or 256-bit keys. It works one round per clock and keeps a single state register. The round keys come from a memory outside the core that has already been filled. The core drives the memory address and reads the data back in the same cycle. The core does not expand keys.

The rounds use the reordered "equivalent" structure. In every middle round, inverse SubBytes, inverse ShiftRows and inverse MixColumns run back to back, and the round-key XOR comes last. Because of this, the keys stored for the middle rounds must already have inverse MixColumns applied. A caller gives a block with a valid/ready handshake and a key-size code. It gets the result back as a one-cycle valid pulse.

Top module: `eqinv_core`

## Requirements
- R1: During and after synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Byte k of a block (k = 0..15) sits at bits [127-8k -: 8] and is state row k mod 4, column k div 4. in_ksize 0, 1 and 2 select 10, 12 and 14 rounds.
- R3: With a 128-bit key schedule loaded, the output is the AES-128 decryption of the input block.
- R4: With a 192-bit key schedule loaded, the output is the AES-192 decryption of the input block.
- R5: With a 256-bit key schedule loaded, the output is the AES-256 decryption of the input block.
- R6: Memory entry i holds round key i. Entries 1 to Nr-1 are stored after inverse MixColumns, and entries 0 and Nr are stored as they are. Memory data is used in the same cycle its address is driven. While the core is idle, rk_addr equals Nr for the present in_ksize. After a block is accepted, rk_addr steps Nr-1, Nr-2, ..., 0, one value per cycle.
- R7: out_valid rises on the Nr-th rising edge after the accepting edge and stays high for exactly one cycle. in_ready returns to 1 on the next edge.
- R8: in_ready is 1 only while the core is idle. When in_ready is 0, in_valid and in_block have no effect on the block being processed.
- R9: in_ksize is sampled when a block is accepted. Changing it during processing does not change the round count or the result.
- R10: in_ksize code 3 behaves the same as code 2 (14 rounds).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ciphertext block offered |
| in_ready | output | 1 | Core idle; block accepted when in_valid is also high |
| in_ksize | input | 2 | Key size: 0=128, 1=192, 2 or 3=256 |
| in_block | input | 128 | Ciphertext block |
| rk_addr | output | 4 | Round-key memory address |
| rk_data | input | 128 | Round key at rk_addr (same cycle) |
| out_valid | output | 1 | Plaintext valid, one-cycle pulse |
| out_block | output | 128 | Plaintext block |

## Verification
The hardest case to reach is a caller that keeps offering a new block, with a different key size, while a block is still running. That stimulus is what would expose a core that re-samples inputs or accepts early. To reach it, the bench raises in_valid with an inverted block and a changed key-size code partway through one decryption. It holds them through the output cycle and then checks the result, the round count, the address walk and in_ready. Correctness rests on published AES vectors for each key size. Further blocks are built by a forward cipher in the bench and sent back through the core to confirm they decrypt.

// File: rtl/aes_eq_pkg.sv
package aes_eq_pkg;

    localparam int BLK_W   = 128;
    localparam int NBYTES  = BLK_W / 8;
    localparam int NCOLS   = NBYTES / 4;
    localparam int RKA_W   = 4;

    typedef logic [7:0]              byte_t;
    typedef logic [0:NBYTES-1][7:0]  blk_t;
    typedef logic [0:3][7:0]         col_t;

    typedef enum logic [1:0] {
        KS_128 = 2'd0,
        KS_192 = 2'd1,
        KS_256 = 2'd2,
        KS_RSV = 2'd3
    } ksize_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    function automatic logic [RKA_W-1:0] nr_of(input logic [1:0] ks);
        case (ksize_e'(ks))
            KS_128:  nr_of = RKA_W'(10);
            KS_192:  nr_of = RKA_W'(12);
            default: nr_of = RKA_W'(14);
        endcase
    endfunction

    function automatic byte_t xt(input byte_t a);
        xt = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xt(sh);
        end
        gmul = acc;
    endfunction

    // multiplicative inverse as a^254; zero maps to zero
    function automatic byte_t ginv(input byte_t a);
        byte_t p;
        byte_t r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        ginv = r;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        rotl8 = byte_t'((a << n) | (a >> (8 - n)));
    endfunction

    function automatic byte_t inv_sub(input byte_t a);
        byte_t t;
        t = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
        inv_sub = ginv(t);
    endfunction

endpackage

// File: rtl/eqinv_mixcol.sv
module eqinv_mixcol
    import aes_eq_pkg::*;
(
    input  col_t col_i,
    output col_t col_o
);
    localparam byte_t C0 = 8'h0e;
    localparam byte_t C1 = 8'h0b;
    localparam byte_t C2 = 8'h0d;
    localparam byte_t C3 = 8'h09;

    for (genvar i = 0; i < 4; i++) begin : g_row
        assign col_o[i] = gmul(col_i[i], C0)
                        ^ gmul(col_i[(i + 1) % 4], C1)
                        ^ gmul(col_i[(i + 2) % 4], C2)
                        ^ gmul(col_i[(i + 3) % 4], C3);
    end
endmodule

// File: rtl/eqinv_round.sv
module eqinv_round
    import aes_eq_pkg::*;
(
    input  blk_t din,
    input  blk_t rkey,
    input  logic last,
    output blk_t dout
);
    blk_t shf;
    blk_t mix;

    // inverse substitution fused with a right rotation of row r by r
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam int ROW = k % 4;
        localparam int COL = k / 4;
        localparam int SRC = ROW + 4 * ((COL - ROW + NCOLS) % NCOLS);
        assign shf[k] = inv_sub(din[SRC]);
    end

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        col_t cin;
        col_t cout;
        assign cin = {shf[4*c], shf[4*c+1], shf[4*c+2], shf[4*c+3]};
        eqinv_mixcol u_mix (.col_i(cin), .col_o(cout));
        for (genvar r = 0; r < 4; r++) begin : g_put
            assign mix[4*c+r] = cout[r];
        end
    end

    assign dout = (last ? shf : mix) ^ rkey;
endmodule

// File: rtl/eqinv_ctrl.sv
module eqinv_ctrl
    import aes_eq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_ksize,
    output logic             in_ready,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             done,
    output logic [RKA_W-1:0] rk_addr
);
    phase_e           phase;
    logic [RKA_W-1:0] rnd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rnd   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (in_valid) begin
                    phase <= PH_RUN;
                    rnd   <= nr_of(in_ksize) - RKA_W'(1);
                end
                PH_RUN: if (rnd == '0) phase <= PH_DONE;
                        else rnd <= rnd - RKA_W'(1);
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign in_ready = (phase == PH_IDLE);
    assign load     = in_ready && in_valid;
    assign step     = (phase == PH_RUN);
    assign last     = (rnd == '0);
    assign done     = (phase == PH_DONE);
    assign rk_addr  = in_ready ? nr_of(in_ksize) : rnd;
endmodule

// File: rtl/eqinv_core.sv
module eqinv_core
    import aes_eq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_ksize,
    input  logic [BLK_W-1:0] in_block,
    output logic [RKA_W-1:0] rk_addr,
    input  logic [BLK_W-1:0] rk_data,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_block
);
    logic load, step, last, done;
    blk_t st;
    blk_t nxt;

    eqinv_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_ksize(in_ksize),
        .in_ready(in_ready),
        .load    (load),
        .step    (step),
        .last    (last),
        .done    (done),
        .rk_addr (rk_addr)
    );

    eqinv_round u_round (
        .din (st),
        .rkey(blk_t'(rk_data)),
        .last(last),
        .dout(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)       st <= '0;
        else if (load) st <= blk_t'(in_block) ^ blk_t'(rk_data);
        else if (step) st <= nxt;
    end

    assign out_valid = done;
    assign out_block = st;
endmodule

// File: rtl/eqinv_core_chk.sv
module eqinv_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [3:0] rk_addr,
    input logic       out_valid
);
    // R7: result strobe lasts one cycle
    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: idle again right after the strobe
    p_ready_after_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> in_ready);

    // R8: no acceptance while the result is shown
    p_busy_out_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R8: accepting a block makes the core busy
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R6: addresses fall by one per processing cycle
    p_addr_desc_r6: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !out_valid && $past(!in_ready))
            |-> rk_addr == 4'($past(rk_addr) - 4'd1));

    // R6: final round uses entry zero
    p_last_key_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rk_addr) == 4'd0);
endmodule

bind eqinv_core eqinv_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .rk_addr  (rk_addr),
    .out_valid(out_valid)
);

// File: tb/sim_eqinv_core.sv
module sim_eqinv_core;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_ksize = 2'd0;
    logic [127:0] in_block = '0;
    logic [3:0]   rk_addr;
    logic [127:0] rk_data;
    logic         out_valid;
    logic [127:0] out_block;

    int checks = 0;
    int fails  = 0;

    logic [127:0] rkm   [0:15];
    logic [127:0] rkp   [0:15];
    logic [31:0]  w     [0:59];

    always #4 clk = ~clk;

    assign rk_data = rkm[rk_addr];

    eqinv_core u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_ksize(in_ksize), .in_block(in_block), .rk_addr(rk_addr),
        .rk_data(rk_data), .out_valid(out_valid), .out_block(out_block)
    );

    // ---------------- reference arithmetic (bench-owned) ----------------
    function automatic logic [7:0] b_xt(input logic [7:0] a);
        b_xt = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] s, x;
        s = 0; x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) s ^= x;
            x = b_xt(x);
        end
        b_mul = s;
    endfunction

    function automatic logic [7:0] b_sbox(input logic [7:0] a);
        logic [7:0] p, r, y;
        p = a; r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = b_mul(p, p);
            r = b_mul(r, p);
        end
        y = r;
        for (int i = 1; i < 5; i++) y ^= 8'((r << i) | (r >> (8 - i)));
        b_sbox = y ^ 8'h63;
    endfunction

    function automatic logic [7:0] gb(input logic [127:0] v, input int k);
        gb = v[127-8*k -: 8];
    endfunction

    function automatic logic [127:0] f_sub(input logic [127:0] v);
        for (int k = 0; k < 16; k++) f_sub[127-8*k -: 8] = b_sbox(gb(v, k));
    endfunction

    function automatic logic [127:0] f_shift(input logic [127:0] v);
        for (int k = 0; k < 16; k++)
            f_shift[127-8*k -: 8] = gb(v, (k % 4) + 4 * (((k / 4) + (k % 4)) % 4));
    endfunction

    function automatic logic [127:0] f_mix(input logic [127:0] v, input bit inv);
        logic [7:0] m0, m1, m2, m3;
        m0 = inv ? 8'h0e : 8'h02; m1 = inv ? 8'h0b : 8'h03;
        m2 = inv ? 8'h0d : 8'h01; m3 = inv ? 8'h09 : 8'h01;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                f_mix[127-8*(4*c+r) -: 8] = b_mul(gb(v, 4*c + r), m0)
                    ^ b_mul(gb(v, 4*c + (r+1)%4), m1)
                    ^ b_mul(gb(v, 4*c + (r+2)%4), m2)
                    ^ b_mul(gb(v, 4*c + (r+3)%4), m3);
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] x);
        subw = {b_sbox(x[31:24]), b_sbox(x[23:16]), b_sbox(x[15:8]), b_sbox(x[7:0])};
    endfunction

    function automatic int nr_for(input logic [1:0] ks);
        nr_for = (ks == 2'd0) ? 10 : (ks == 2'd1) ? 12 : 14;
    endfunction

    // fills rkp (plain) and rkm (memory image, middle keys inverse-mixed)
    task automatic load_keys(input logic [1:0] ks, input logic [255:0] key);
        int nr, nk;
        logic [31:0] t;
        logic [7:0]  rc;
        nr = nr_for(ks); nk = nr - 6; rc = 8'h01;
        for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
        for (int i = nk; i < 4*(nr+1); i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = b_xt(rc);
            end else if (nk == 8 && i % nk == 4) begin
                t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r < 16; r++) begin
            rkp[r] = '0; rkm[r] = '0;
        end
        for (int r = 0; r <= nr; r++) begin
            rkp[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
            rkm[r] = (r == 0 || r == nr) ? rkp[r] : f_mix(rkp[r], 1'b1);
        end
    endtask

    function automatic logic [127:0] encrypt(input int nr, input logic [127:0] pt);
        logic [127:0] s;
        s = pt ^ rkp[0];
        for (int r = 1; r < nr; r++) s = f_mix(f_shift(f_sub(s)), 1'b0) ^ rkp[r];
        encrypt = f_shift(f_sub(s)) ^ rkp[nr];
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one block end to end; disturb drives a competing request mid-run
    task automatic run_block(input logic [1:0] ks, input logic [127:0] ct,
                             input logic [127:0] exp, input string req, input bit disturb);
        int nr, lat;
        bit addr_ok, busy_ok;
        nr = nr_for(ks);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_ksize = ks; in_block = ct;
        #1;
        chk(rk_addr == 4'(nr), "R6", "idle address", 128'(rk_addr), 128'(nr));
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        lat = 0; addr_ok = 1; busy_ok = 1;
        while (!out_valid && lat < 40) begin
            if (in_ready) busy_ok = 0;
            if (rk_addr != 4'(nr - 1 - lat)) addr_ok = 0;
            if (disturb && lat == 2) begin
                in_valid = 1'b1; in_ksize = ks ^ 2'b11; in_block = ~ct;
            end
            @(posedge clk); @(negedge clk);
            lat++;
        end
        if (disturb) begin
            chk(in_ready == 1'b0, "R8", "busy during output", 128'(in_ready), 128'(0));
            in_valid = 1'b0;
            chk(out_block == exp, "R9", "ksize change ignored", out_block, exp);
        end
        chk(lat == nr, "R7", "latency", 128'(lat), 128'(nr));
        chk(out_block == exp, req, "plaintext", out_block, exp);
        chk(addr_ok, "R6", "address walk", 128'(addr_ok), 128'(1));
        chk(busy_ok, "R8", "in_ready low while busy", 128'(busy_ok), 128'(1));
        @(posedge clk); @(negedge clk);
        chk(out_valid == 1'b0, "R7", "single-cycle strobe", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R7", "ready after strobe", 128'(in_ready), 128'(1));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R1", "in_ready in reset", 128'(in_ready), 128'(1));
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 128'(in_ready), 128'(1));
    endtask

    localparam logic [127:0] PT_STD = 128'h00112233445566778899aabbccddeeff;

    // known vectors; byte order per R2
    task automatic t_known();
        load_keys(2'd0, {128'h000102030405060708090a0b0c0d0e0f, 128'h0});
        run_block(2'd0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, PT_STD, "R3", 0);
        load_keys(2'd1, {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0});
        run_block(2'd1, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, PT_STD, "R4", 0);
        load_keys(2'd2, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f);
        run_block(2'd2, 128'h8ea2b7ca516745bfeafc49904b496089, PT_STD, "R5", 0);
    endtask

    task automatic t_roundtrip();
        logic [255:0] key;
        logic [127:0] pt;
        for (int ks = 0; ks < 3; ks++) begin
            key = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            load_keys(2'(ks), key);
            for (int n = 0; n < 2; n++) begin
                pt = {$urandom, $urandom, $urandom, $urandom};
                run_block(2'(ks), encrypt(nr_for(2'(ks)), pt), pt,
                          ks == 0 ? "R3" : ks == 1 ? "R4" : "R5", 0);
            end
        end
    endtask

    task automatic t_reserved_code();
        logic [127:0] pt;
        load_keys(2'd2, 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4);
        pt = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        run_block(2'd3, encrypt(14, pt), pt, "R10", 0);
    endtask

    task automatic t_busy_disturb();
        logic [127:0] pt;
        load_keys(2'd0, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0});
        pt = 128'h6bc1bee22e409f96e93d7e117393172a;
        run_block(2'd0, encrypt(10, pt), pt, "R8", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) begin
            rkm[r] = '0; rkp[r] = '0;
        end
        repeat (2) @(posedge clk);
        t_reset();
        t_known();
        t_roundtrip();
        t_reserved_code();
        t_busy_disturb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule